// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Multiprocessor Wake-up

This block frames characters arriving on an asynchronous serial line and hands each finished byte to the surrounding logic. Each bit period is sixteen sample ticks wide, and each bit is taken at the middle of its period. A character has a start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. Parity can be enabled or disabled, and when enabled it is checked as even or odd. Three status flags cover a received byte, an idle line and a parity mismatch. Each flag has its own interrupt enable, and one combined interrupt output carries them all. An overrun flag records a character that arrived while the previous byte was still unread.

Several nodes can share one line. Software puts a node to sleep with a one-cycle request, and a sleeping node discards the traffic meant for other nodes. A control input selects how the node wakes. The first choice wakes it after one full character time of idle line. The second wakes it on a character whose most significant data bit is 1, and that character is itself received. A second control input selects when idle counting begins. It can begin at the first high sample after any low bit, so stop bits and trailing data ones count toward idle. It can instead begin only once the stop bit has been sampled.

Top module: `uart_wake_rx`

## Requirements
- R1: After reset, `rxFull`, `overrun`, `parityErr`, `idleFlag`, `asleep` and `irq` are all 0.
- R2: A frame is one low start bit, then 8 data bits with the LSB first, then a parity bit only if `parityEn` is 1, then a high stop bit. Each bit lasts 16 asserted `sampleTick` cycles and is sampled at mid-bit. When a character completes and `rxFull` is 0, `rxData` takes the byte and `rxFull` is set.
- R3: If the start bit is high again when it is sampled at mid-bit, the receiver discards it and returns to hunting for a start. It does not set `rxFull`, and it still receives the next correct frame.
- R4: When `parityEn` is 1, the expected parity bit is the XOR of the 8 data bits, and that value is inverted when `parityOdd` is 1. So with even parity, an even count of ones gives a 0. `parityErr` is set when the received parity bit differs from the expected one. `parityErr` can only be set while `parityEn` is 1.
- R5: If a character completes while `rxFull` is 1 and `flagClr` is 0, `overrun` is set and `rxData` keeps the old byte. A `flagClr` pulse clears `rxFull`, `overrun`, `parityErr` and `idleFlag`.
- R6: While `rxEn` is 0, the receiver ignores the line. No character is received and no idle is counted.
- R7: A `sleepReq` pulse sets `asleep`. While the receiver is asleep, a completed character does not set `rxFull` or `parityErr`, except for the waking character described in R8.
- R8: When `wakeSel` is 1 and the receiver is asleep, a character with data bit 7 equal to 1 clears `asleep`, is loaded into `rxData` and sets `rxFull`. A character with bit 7 equal to 0 is discarded.
- R9: When `wakeSel` is 0 and the receiver is asleep, detecting idle clears `asleep` and leaves `idleFlag` at 0. While the receiver is awake, detecting idle sets `idleFlag`.
- R10: Idle is a run of line-high ticks equal to 10 bit times, or 11 bit times when `parityEn` is 1. Idle is detected at most once between low bits, and not before the first low bit after reset.
- R11: When `idleType` is 0, the idle count runs whenever the line is high, starting after any low bit. When `idleType` is 1, it runs only after the stop bit has been sampled.
- R12: `irq` is 1 when any of the following holds: `rxFullIe` is 1 and either `rxFull` or `overrun` is 1; `idleIe` is 1 and `idleFlag` is 1; `perrIe` is 1 and `parityErr` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleTick | input | 1 | Oversampling tick, 16 per bit time |
| serialIn | input | 1 | Serial line, idles high |
| rxEn | input | 1 | Receiver enable |
| wakeSel | input | 1 | Wake condition: 0 idle line, 1 address-marked character |
| idleType | input | 1 | Idle count start: 0 after any low bit, 1 after the stop bit |
| parityEn | input | 1 | Parity bit present and checked |
| parityOdd | input | 1 | 0 even parity, 1 odd parity |
| rxFullIe | input | 1 | Interrupt enable for received byte and overrun |
| idleIe | input | 1 | Interrupt enable for idle |
| perrIe | input | 1 | Interrupt enable for parity error |
| sleepReq | input | 1 | One-cycle request to enter sleep |
| flagClr | input | 1 | One-cycle clear of all status flags |
| rxData | output | 8 | Last accepted byte |
| rxFull | output | 1 | Byte available |
| overrun | output | 1 | Character lost because `rxFull` was still set |
| parityErr | output | 1 | Parity mismatch on an accepted byte |
| idleFlag | output | 1 | Idle line seen while awake |
| asleep | output | 1 | Receiver is in sleep |
| irq | output | 1 | Combined interrupt |

## Verification
The bench sends a byte ending in a high bit 7 and times the idle flag against both count-start settings. A receiver that started counting at the wrong point would flag idle about one and a half bit times early or late. The bench repeats the timing check with parity enabled, which exposes a count fixed at ten bit times. Sleep tests send a non-marked character and then a marked one. A design that leaked sleeping traffic would set `rxFull` on the first, and one that dropped the waking character would miss the second. The bench also covers a false start, overrun with the old byte kept, idle wake with no idle flag, and both parity senses. A wrong XOR sense or a missing false-start check shows up as a flag with the wrong value.

// File: rtl/uwr_pkg.sv
package uwr_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;    // restart tick and bit counters
    logic shift;     // shift the sampled line into the data register
    logic capPar;    // capture the parity bit
    logic load;      // move the shifted byte to the output register
    logic idleGate;  // idle counter may run
  } dpCtl_t;

  // Status from datapath to control
  typedef struct packed {
    logic lineLow;
    logic halfBit;
    logic fullBit;
    logic lastBit;
    logic idleHit;
    logic shMsb;
    logic parBad;
  } dpSts_t;

endpackage

// File: rtl/uwr_datapath.sv
module uwr_datapath
  import uwr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              sampleTick,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  dpCtl_t            ctl,
  output dpSts_t            sts,
  output logic [DATA_W-1:0] rxData
);

  localparam int CW        = $clog2(OSR);
  localparam int BW        = $clog2(DATA_W);
  localparam int IDLE_BASE = (DATA_W + 2) * OSR;
  localparam int IDLE_PAR  = (DATA_W + 3) * OSR;
  localparam int IW        = $clog2(IDLE_PAR + 1);

  logic [1:0]        syncQ;
  logic              rxLine;
  logic [CW-1:0]     tickCnt;
  logic [BW-1:0]     bitCnt;
  logic [DATA_W-1:0] shReg;
  logic              parReg;
  logic [IW-1:0]     idleCnt;
  logic              idleSeen;
  logic [IW-1:0]     idleLimit;
  logic              idleHit;

  // Two-flop synchronizer, line idles high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= 2'b11;
    else       syncQ <= {syncQ[0], serialIn};
  end
  assign rxLine = syncQ[1];

  // Oversample tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (ctl.cntClr) begin
      tickCnt <= '0;
    end else if (sampleTick) begin
      if (tickCnt == CW'(OSR - 1)) tickCnt <= '0;
      else                         tickCnt <= tickCnt + 1'b1;
    end
  end

  // Bit counter and shift register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (ctl.cntClr) begin
      bitCnt <= '0;
    end else if (ctl.shift) begin
      bitCnt <= bitCnt + 1'b1;
      shReg  <= {rxLine, shReg[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           parReg <= 1'b0;
    else if (ctl.capPar) parReg <= rxLine;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rxData <= '0;
    else if (ctl.load) rxData <= shReg;
  end

  // Idle counter: one full character time of ones
  assign idleLimit = parityEn ? IW'(IDLE_PAR - 1) : IW'(IDLE_BASE - 1);
  assign idleHit   = rxLine && ctl.idleGate && sampleTick && !idleSeen
                     && (idleCnt == idleLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt  <= '0;
      idleSeen <= 1'b1;
    end else if (!rxLine) begin
      idleCnt  <= '0;
      idleSeen <= 1'b0;
    end else if (!ctl.idleGate) begin
      idleCnt  <= '0;
    end else if (sampleTick && !idleSeen) begin
      if (idleCnt == idleLimit) begin
        idleCnt  <= '0;
        idleSeen <= 1'b1;
      end else begin
        idleCnt  <= idleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    sts.lineLow = !rxLine;
    sts.halfBit = sampleTick && (tickCnt == CW'(OSR / 2 - 1));
    sts.fullBit = sampleTick && (tickCnt == CW'(OSR - 1));
    sts.lastBit = (bitCnt == BW'(DATA_W - 1));
    sts.idleHit = idleHit;
    sts.shMsb   = shReg[DATA_W-1];
    sts.parBad  = (^shReg) ^ parityOdd ^ parReg;
  end

endmodule

// File: rtl/uwr_ctrl.sv
module uwr_ctrl
  import uwr_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   rxEn,
  input  logic   wakeSel,
  input  logic   idleType,
  input  logic   parityEn,
  input  logic   rxFullIe,
  input  logic   idleIe,
  input  logic   perrIe,
  input  logic   sleepReq,
  input  logic   flagClr,
  input  dpSts_t sts,
  output dpCtl_t ctl,
  output logic   rxFull,
  output logic   overrun,
  output logic   parityErr,
  output logic   idleFlag,
  output logic   asleep,
  output logic   irq
);

  rxState_t state, stateNxt;
  logic     frameDone;
  logic     wakeAddr;
  logic     frameOk;
  logic     fullEff;
  logic     wakeIdle;

  always_comb begin
    stateNxt   = state;
    frameDone  = 1'b0;
    ctl.cntClr = 1'b0;
    ctl.shift  = 1'b0;
    ctl.capPar = 1'b0;
    if (!rxEn) begin
      stateNxt = ST_HUNT;
    end else begin
      unique case (state)
        ST_HUNT: if (sts.lineLow) begin
          ctl.cntClr = 1'b1;
          stateNxt   = ST_START;
        end
        ST_START: if (sts.halfBit) begin
          if (sts.lineLow) begin
            ctl.cntClr = 1'b1;
            stateNxt   = ST_DATA;
          end else begin
            stateNxt   = ST_HUNT;
          end
        end
        ST_DATA: if (sts.fullBit) begin
          ctl.shift = 1'b1;
          if (sts.lastBit) stateNxt = parityEn ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (sts.fullBit) begin
          ctl.capPar = 1'b1;
          stateNxt   = ST_STOP;
        end
        ST_STOP: if (sts.fullBit) begin
          frameDone = 1'b1;
          stateNxt  = ST_HUNT;
        end
        default: stateNxt = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= stateNxt;
  end

  assign ctl.idleGate = rxEn && (idleType ? (state == ST_HUNT) : 1'b1);

  assign wakeAddr = asleep && wakeSel && sts.shMsb;
  assign frameOk  = frameDone && (!asleep || wakeAddr);
  assign fullEff  = rxFull && !flagClr;
  assign ctl.load = frameOk && !fullEff;
  assign wakeIdle = sts.idleHit && !wakeSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxFull    <= 1'b0;
      overrun   <= 1'b0;
      parityErr <= 1'b0;
      idleFlag  <= 1'b0;
      asleep    <= 1'b0;
    end else begin
      rxFull    <= fullEff || ctl.load;
      overrun   <= (overrun && !flagClr) || (frameOk && fullEff);
      parityErr <= (parityErr && !flagClr) || (ctl.load && parityEn && sts.parBad);
      idleFlag  <= (idleFlag && !flagClr) || (sts.idleHit && !asleep);
      if (sleepReq)                           asleep <= 1'b1;
      else if ((frameDone && wakeAddr) || wakeIdle) asleep <= 1'b0;
    end
  end

  assign irq = (rxFullIe && (rxFull || overrun)) || (idleIe && idleFlag)
               || (perrIe && parityErr);

endmodule

// File: rtl/uart_wake_rx.sv
module uart_wake_rx
  import uwr_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleTick,
  input  logic              serialIn,
  input  logic              rxEn,
  input  logic              wakeSel,
  input  logic              idleType,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              rxFullIe,
  input  logic              idleIe,
  input  logic              perrIe,
  input  logic              sleepReq,
  input  logic              flagClr,
  output logic [DATA_W-1:0] rxData,
  output logic              rxFull,
  output logic              overrun,
  output logic              parityErr,
  output logic              idleFlag,
  output logic              asleep,
  output logic              irq
);

  dpCtl_t ctl;
  dpSts_t sts;

  uwr_datapath #(.OSR(OSR), .DATA_W(DATA_W)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .sampleTick(sampleTick),
    .parityEn  (parityEn),
    .parityOdd (parityOdd),
    .ctl       (ctl),
    .sts       (sts),
    .rxData    (rxData)
  );

  uwr_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .rxEn     (rxEn),
    .wakeSel  (wakeSel),
    .idleType (idleType),
    .parityEn (parityEn),
    .rxFullIe (rxFullIe),
    .idleIe   (idleIe),
    .perrIe   (perrIe),
    .sleepReq (sleepReq),
    .flagClr  (flagClr),
    .sts      (sts),
    .ctl      (ctl),
    .rxFull   (rxFull),
    .overrun  (overrun),
    .parityErr(parityErr),
    .idleFlag (idleFlag),
    .asleep   (asleep),
    .irq      (irq)
  );

endmodule

// File: rtl/uwr_checker.sv
module uwr_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEn,
  input logic              parityEn,
  input logic              flagClr,
  input logic              rxFullIe,
  input logic              idleIe,
  input logic              perrIe,
  input logic [DATA_W-1:0] rxData,
  input logic              rxFull,
  input logic              overrun,
  input logic              parityErr,
  input logic              idleFlag,
  input logic              asleep,
  input logic              irq
);

  p_overrun_keeps_data_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $stable(rxData));

  p_clr_drops_overrun_r5: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagClr) |-> !overrun);

  p_disabled_no_rx_r6: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rxEn) |-> !$rose(rxFull));

  p_parity_needs_en_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(parityErr) |-> $past(parityEn));

  p_sleep_blocks_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> !($past(asleep) && asleep));

  p_no_idle_asleep_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(idleFlag) |-> !$past(asleep));

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!rxFullIe && !idleIe && !perrIe) |-> !irq);

endmodule

bind uart_wake_rx uwr_checker #(.DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .rxEn     (rxEn),
  .parityEn (parityEn),
  .flagClr  (flagClr),
  .rxFullIe (rxFullIe),
  .idleIe   (idleIe),
  .perrIe   (perrIe),
  .rxData   (rxData),
  .rxFull   (rxFull),
  .overrun  (overrun),
  .parityErr(parityErr),
  .idleFlag (idleFlag),
  .asleep   (asleep),
  .irq      (irq)
);

// File: tb/uart_wake_rx_tb_top.sv
module uart_wake_rx_tb_top;

  localparam int OSR = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b1;
  logic       serialIn = 1'b1;
  logic       rxEn = 1'b0;
  logic       wakeSel = 1'b0;
  logic       idleType = 1'b0;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic       rxFullIe = 1'b0;
  logic       idleIe = 1'b0;
  logic       perrIe = 1'b0;
  logic       sleepReq = 1'b0;
  logic       flagClr = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, overrun, parityErr, idleFlag, asleep, irq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;

  uart_wake_rx dut_i (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick), .serialIn(serialIn),
    .rxEn(rxEn), .wakeSel(wakeSel), .idleType(idleType), .parityEn(parityEn),
    .parityOdd(parityOdd), .rxFullIe(rxFullIe), .idleIe(idleIe), .perrIe(perrIe),
    .sleepReq(sleepReq), .flagClr(flagClr), .rxData(rxData), .rxFull(rxFull),
    .overrun(overrun), .parityErr(parityErr), .idleFlag(idleFlag),
    .asleep(asleep), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitOut(input logic b);
    serialIn = b;
    repeat (OSR) @(negedge clk);
  endtask

  // Ends at the negedge closing the stop bit
  task automatic sendFrame(input logic [7:0] d, input logic withPar, input logic p);
    bitOut(1'b0);
    for (int i = 0; i < 8; i++) bitOut(d[i]);
    if (withPar) bitOut(p);
    bitOut(1'b1);
  endtask

  task automatic pulseClr();
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulseSleep();
    sleepReq = 1'b1;
    @(negedge clk);
    sleepReq = 1'b0;
    @(negedge clk);
  endtask

  task automatic tResetState();
    check("R1 rxFull", rxFull, 0);
    check("R1 overrun", overrun, 0);
    check("R1 parityErr", parityErr, 0);
    check("R1 idleFlag", idleFlag, 0);
    check("R1 asleep", asleep, 0);
    check("R1 irq", irq, 0);
  endtask

  task automatic tBasic();
    pulseClr();
    rxFullIe = 1'b0;
    sendFrame(8'hA5, 1'b0, 1'b0);
    check("R2 rxFull", rxFull, 1);
    check("R2 rxData", rxData, 8'hA5);
    check("R12 irq masked", irq, 0);
    rxFullIe = 1'b1;
    @(negedge clk);
    check("R12 irq enabled", irq, 1);
    pulseClr();
    sendFrame(8'h3C, 1'b0, 1'b0);
    check("R2 rxData second", rxData, 8'h3C);
    rxFullIe = 1'b0;
    pulseClr();
  endtask

  task automatic tFalseStart();
    serialIn = 1'b0;
    repeat (5) @(negedge clk);
    serialIn = 1'b1;
    repeat (40) @(negedge clk);
    check("R3 no byte from glitch", rxFull, 0);
    sendFrame(8'h5A, 1'b0, 1'b0);
    check("R3 next frame rxFull", rxFull, 1);
    check("R3 next frame data", rxData, 8'h5A);
    pulseClr();
  endtask

  task automatic tParity();
    parityEn = 1'b1;
    parityOdd = 1'b0;
    sendFrame(8'h03, 1'b1, 1'b0);
    check("R4 even ok data", rxData, 8'h03);
    check("R4 even ok", parityErr, 0);
    pulseClr();
    sendFrame(8'h07, 1'b1, 1'b0);
    check("R4 even bad", parityErr, 1);
    perrIe = 1'b1;
    @(negedge clk);
    check("R12 irq parity", irq, 1);
    perrIe = 1'b0;
    pulseClr();
    parityOdd = 1'b1;
    sendFrame(8'h07, 1'b1, 1'b0);
    check("R4 odd ok", parityErr, 0);
    pulseClr();
    sendFrame(8'h03, 1'b1, 1'b0);
    check("R4 odd bad", parityErr, 1);
    pulseClr();
    parityEn = 1'b0;
    parityOdd = 1'b0;
    sendFrame(8'h07, 1'b0, 1'b0);
    check("R4 disabled no err", parityErr, 0);
    check("R4 disabled data", rxData, 8'h07);
    pulseClr();
  endtask

  task automatic tOverrun();
    sendFrame(8'h11, 1'b0, 1'b0);
    sendFrame(8'h22, 1'b0, 1'b0);
    check("R5 overrun set", overrun, 1);
    check("R5 old data kept", rxData, 8'h11);
    pulseClr();
    check("R5 clr overrun", overrun, 0);
    check("R5 clr rxFull", rxFull, 0);
  endtask

  task automatic tDisabled();
    rxEn = 1'b0;
    sendFrame(8'h66, 1'b0, 1'b0);
    repeat (200) @(negedge clk);
    check("R6 no byte", rxFull, 0);
    check("R6 no idle", idleFlag, 0);
    rxEn = 1'b1;
    sendFrame(8'h66, 1'b0, 1'b0);
    check("R6 enabled again", rxFull, 1);
    pulseClr();
  endtask

  task automatic tAddrWake();
    wakeSel = 1'b1;
    pulseSleep();
    check("R7 asleep set", asleep, 1);
    sendFrame(8'h12, 1'b0, 1'b0);
    check("R8 unmarked dropped", rxFull, 0);
    check("R8 still asleep", asleep, 1);
    repeat (200) @(negedge clk);
    check("R8 idle no wake", asleep, 1);
    sendFrame(8'h92, 1'b0, 1'b0);
    check("R8 woke", asleep, 0);
    check("R8 marked received", rxFull, 1);
    check("R8 marked data", rxData, 8'h92);
    pulseClr();
    wakeSel = 1'b0;
  endtask

  task automatic tIdleWake();
    idleType = 1'b1;
    wakeSel = 1'b0;
    pulseSleep();
    parityEn = 1'b1;
    sendFrame(8'h07, 1'b1, 1'b0);
    check("R7 no byte asleep", rxFull, 0);
    check("R7 no parity err asleep", parityErr, 0);
    parityEn = 1'b0;
    sendFrame(8'h34, 1'b0, 1'b0);
    repeat (175) @(negedge clk);
    check("R9 idle woke", asleep, 0);
    check("R9 no flag on wake", idleFlag, 0);
    sendFrame(8'h55, 1'b0, 1'b0);
    repeat (175) @(negedge clk);
    check("R9 awake idle flag", idleFlag, 1);
    idleIe = 1'b1;
    @(negedge clk);
    check("R12 irq idle", irq, 1);
    idleIe = 1'b0;
    pulseClr();
  endtask

  task automatic tIdleTiming();
    idleType = 1'b0;
    sendFrame(8'h80, 1'b0, 1'b0);
    repeat (143) @(negedge clk);
    check("R11 type0 early idle", idleFlag, 1);
    pulseClr();
    idleType = 1'b1;
    sendFrame(8'h80, 1'b0, 1'b0);
    repeat (143) @(negedge clk);
    check("R11 type1 not yet", idleFlag, 0);
    repeat (32) @(negedge clk);
    check("R11 type1 idle", idleFlag, 1);
    pulseClr();
    repeat (200) @(negedge clk);
    check("R10 once per idle", idleFlag, 0);
    parityEn = 1'b1;
    sendFrame(8'h80, 1'b1, 1'b0);
    repeat (160) @(negedge clk);
    check("R10 parity lengthens idle", idleFlag, 0);
    repeat (25) @(negedge clk);
    check("R10 parity idle", idleFlag, 1);
    parityEn = 1'b0;
    pulseClr();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    tResetState();
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    tResetState();
    rxEn = 1'b1;
    repeat (2) @(negedge clk);
    tBasic();
    tFalseStart();
    tParity();
    tOverrun();
    tDisabled();
    tAddrWake();
    tIdleWake();
    tIdleTiming();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule